// File: doc/BRIEF.md
# Stereo Linear Volume and Peak Detector

This block is the last digital stage of a stereo record path. It takes one 24-bit two's complement sample pair per input strobe and scales each channel by its own 8-bit attenuation code. The volume law is linear: each step of the code removes 1/256 of full scale, so the output is the input times (256 − code) / 256. A mute input forces both outputs to zero. The scaled pair comes out of a register one clock after the strobe, and a valid strobe marks it.

Each channel also has a peak-hold register. It records the largest input magnitude seen since that register was last read, and the magnitude is taken before any scaling or mute. A one-cycle read strobe for a channel empties that register, so the next reading covers a fresh interval. Software or a level-control loop can use the peak values to set the input gain.

Top module: `stereo_gain_peak`

## Requirements
- R1: After reset, `outValid` is 0, both scaled outputs are 0 and both peak outputs are 0.
- R2: `outValid` is high exactly in the cycle after a cycle with `inValid` high. The scaled outputs change only in that cycle and otherwise hold their value.
- R3: For a non-muted sample s with code v, the output is s·(256 − v)/256 rounded toward zero. Left uses `volLeft` and right uses `volRight`, independently of each other.
- R4: Code 0 passes the sample unchanged.
- R5: Code 255 gives s/256 rounded toward zero, which is the deepest non-muted attenuation (about −48 dB). For example, −8388608 gives −32768, and any magnitude below 256 gives 0.
- R6: With `muteIn` high on a valid sample, both outputs are exactly 0 whatever the codes are. The peak registers still take in that sample.
- R7: Each peak output holds the largest |s| of the valid samples since the last read or reset. It is updated one cycle after the sample, and neither volume nor mute affects it.
- R8: The magnitude of −8388608 (0x800000) is taken as 8388607 (0x7FFFFF). A peak value never has bit 23 set.
- R9: A read strobe with no sample in the same cycle sets that channel's peak to 0 in the next cycle. The other channel's peak does not change.
- R10: When a read strobe and a valid sample fall in the same cycle, the peak output in that cycle still shows the old value. In the next cycle the register holds the new sample's magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; clears the outputs and the peaks |
| inValid | input | 1 | Sample pair strobe |
| inLeft | input | 24 | Left input sample, two's complement |
| inRight | input | 24 | Right input sample, two's complement |
| volLeft | input | 8 | Left attenuation code, 0 = unity |
| volRight | input | 8 | Right attenuation code, 0 = unity |
| muteIn | input | 1 | Forces both scaled outputs to zero |
| rdPeakLeft | input | 1 | Read strobe for the left peak; clears it |
| rdPeakRight | input | 1 | Read strobe for the right peak; clears it |
| outValid | output | 1 | Scaled pair valid |
| outLeft | output | 24 | Left scaled sample |
| outRight | output | 24 | Right scaled sample |
| peakLeft | output | 24 | Left peak magnitude, unsigned |
| peakRight | output | 24 | Right peak magnitude, unsigned |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid latency and holding of the outputs;
- unity pass-through at code 0;
- zero output under mute;
- a peak value that does not fall without a read;
- clearing on a read;
- saturation of the most negative sample;
- restart from a sample that arrives together with a read.

Only the bench scenarios can show two things. The first is the exact value of each scaled result across codes and signs, including rounding toward zero for negative products. The second is that the peak tracks the true maximum over a run of samples while the volume is at its deepest or the output is muted.

// File: rtl/svp_pkg.sv
package svp_pkg;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic              load;
    logic              mute;
    logic [NUM_CH-1:0] clr;
  } ctrlStrobes_t;
endpackage

// File: rtl/svp_ctrl.sv
module svp_ctrl
  import svp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              muteIn,
  input  logic [NUM_CH-1:0] rdPeak,
  output ctrlStrobes_t      strb,
  output logic              outValid
);
  always_comb begin
    strb.load = inValid;
    strb.mute = muteIn;
    strb.clr  = rdPeak;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/svp_datapath.sv
module svp_datapath
  import svp_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int VOL_W  = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStrobes_t                   strb,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  sampIn,
  input  logic [NUM_CH-1:0][VOL_W-1:0]   volIn,
  output logic [NUM_CH-1:0][DATA_W-1:0]  sampOut,
  output logic [NUM_CH-1:0][DATA_W-1:0]  peakOut
);
  localparam int PROD_W = DATA_W + VOL_W;
  localparam int STEPS  = 1 << VOL_W;
  localparam logic [DATA_W-1:0] MAX_POS  = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    logic [VOL_W:0]            factor;
    logic signed [PROD_W-1:0]  sExt;
    logic signed [PROD_W-1:0]  fExt;
    logic signed [PROD_W-1:0]  prod;
    logic [DATA_W-1:0]         floorQ;
    logic                      roundUp;
    logic [DATA_W-1:0]         scaled;
    logic [DATA_W-1:0]         mag;
    logic [DATA_W-1:0]         outQ;
    logic [DATA_W-1:0]         peakQ;

    always_comb begin
      factor  = (VOL_W+1)'(STEPS) - {1'b0, volIn[c]};
      sExt    = PROD_W'($signed(sampIn[c]));
      fExt    = PROD_W'({1'b0, factor});
      prod    = sExt * fExt;
      // floor division by 2^VOL_W, then step toward zero for inexact negatives
      floorQ  = prod[PROD_W-1:VOL_W];
      roundUp = prod[PROD_W-1] & (|prod[VOL_W-1:0]);
      scaled  = floorQ + DATA_W'(roundUp);
      if (!sampIn[c][DATA_W-1])    mag = sampIn[c];
      else if (sampIn[c] == MOST_NEG) mag = MAX_POS;
      else                         mag = ~sampIn[c] + 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outQ  <= '0;
        peakQ <= '0;
      end else begin
        if (strb.load) outQ <= strb.mute ? '0 : scaled;
        if (strb.clr[c])                   peakQ <= strb.load ? mag : '0;
        else if (strb.load && mag > peakQ) peakQ <= mag;
      end
    end

    assign sampOut[c] = outQ;
    assign peakOut[c] = peakQ;
  end
endmodule

// File: rtl/stereo_gain_peak.sv
module stereo_gain_peak
  import svp_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int VOL_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inLeft,
  input  logic [DATA_W-1:0] inRight,
  input  logic [VOL_W-1:0]  volLeft,
  input  logic [VOL_W-1:0]  volRight,
  input  logic              muteIn,
  input  logic              rdPeakLeft,
  input  logic              rdPeakRight,
  output logic              outValid,
  output logic [DATA_W-1:0] outLeft,
  output logic [DATA_W-1:0] outRight,
  output logic [DATA_W-1:0] peakLeft,
  output logic [DATA_W-1:0] peakRight
);
  ctrlStrobes_t                  strb;
  logic [NUM_CH-1:0][DATA_W-1:0] sampOut;
  logic [NUM_CH-1:0][DATA_W-1:0] peakOut;

  svp_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .muteIn   (muteIn),
    .rdPeak   ({rdPeakRight, rdPeakLeft}),
    .strb     (strb),
    .outValid (outValid)
  );

  svp_datapath #(.DATA_W(DATA_W), .VOL_W(VOL_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .sampIn  ({inRight, inLeft}),
    .volIn   ({volRight, volLeft}),
    .sampOut (sampOut),
    .peakOut (peakOut)
  );

  assign outLeft   = sampOut[0];
  assign outRight  = sampOut[1];
  assign peakLeft  = peakOut[0];
  assign peakRight = peakOut[1];
endmodule

// File: rtl/svp_checker.sv
module svp_checker #(
  parameter int DATA_W = 24,
  parameter int VOL_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] inLeft,
  input logic [DATA_W-1:0] inRight,
  input logic [VOL_W-1:0]  volLeft,
  input logic              muteIn,
  input logic              rdPeakLeft,
  input logic              rdPeakRight,
  input logic              outValid,
  input logic [DATA_W-1:0] outLeft,
  input logic [DATA_W-1:0] outRight,
  input logic [DATA_W-1:0] peakLeft,
  input logic [DATA_W-1:0] peakRight
);
  localparam logic [DATA_W-1:0] MAX_POS  = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid && $stable(outLeft) && $stable(outRight)); // R2
  AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !muteIn && volLeft == '0 |=> outLeft == $past(inLeft)); // R4
  AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    inValid && muteIn |=> outLeft == '0 && outRight == '0); // R6
  AST_PEAK_NO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !rdPeakLeft |=> peakLeft >= $past(peakLeft)); // R7
  AST_PEAK_NO_DROP_R: assert property (@(posedge clk) disable iff (!rstN)
    !rdPeakRight |=> peakRight >= $past(peakRight)); // R7
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !rdPeakLeft && inLeft == MOST_NEG |=> peakLeft == MAX_POS); // R8
  AST_PEAK_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    !peakLeft[DATA_W-1] && !peakRight[DATA_W-1]); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    rdPeakLeft && !inValid |=> peakLeft == '0); // R9
  AST_READ_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    rdPeakRight && inValid && !inRight[DATA_W-1] |=> peakRight == $past(inRight)); // R10
endmodule

bind stereo_gain_peak svp_checker #(.DATA_W(DATA_W), .VOL_W(VOL_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .inLeft      (inLeft),
  .inRight     (inRight),
  .volLeft     (volLeft),
  .muteIn      (muteIn),
  .rdPeakLeft  (rdPeakLeft),
  .rdPeakRight (rdPeakRight),
  .outValid    (outValid),
  .outLeft     (outLeft),
  .outRight    (outRight),
  .peakLeft    (peakLeft),
  .peakRight   (peakRight)
);

// File: tb/stereo_gain_peak_test.sv
`timescale 1ns/1ps
module stereo_gain_peak_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [23:0] inLeft = '0, inRight = '0;
  logic [7:0]  volLeft = '0, volRight = '0;
  logic        muteIn = 1'b0, rdPeakLeft = 1'b0, rdPeakRight = 1'b0;
  logic        outValid;
  logic [23:0] outLeft, outRight, peakLeft, peakRight;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [23:0] l;
    logic [23:0] r;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  logic [23:0] pkL = '0, pkR = '0;
  string       prevTag = "R1";
  logic [23:0] lastL = '0, lastR = '0;

  stereo_gain_peak uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLeft(inLeft), .inRight(inRight),
    .volLeft(volLeft), .volRight(volRight), .muteIn(muteIn),
    .rdPeakLeft(rdPeakLeft), .rdPeakRight(rdPeakRight), .outValid(outValid),
    .outLeft(outLeft), .outRight(outRight), .peakLeft(peakLeft), .peakRight(peakRight)
  );

  always #10 clk = ~clk;

  task automatic checkVal(string what, string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [23:0] magOf(logic signed [23:0] s);
    if (s == 24'sh800000) return 24'h7FFFFF;
    if (s < 0) return 24'(-s);
    return s;
  endfunction

  function automatic logic [23:0] scaleOf(logic signed [23:0] s, logic [7:0] v, logic m);
    longint p;
    if (m) return '0;
    p = longint'(s) * longint'(256 - int'(v));
    if (p < 0) return 24'(-((-p) / 256));
    return 24'(p / 256);
  endfunction

  // one cycle of stimulus; first checks peaks produced by the previous cycle
  task automatic step(logic v, logic signed [23:0] l, logic signed [23:0] r,
                      logic [7:0] vl, logic [7:0] vr, logic m,
                      logic rl, logic rr, string tag);
    expItem_t it;
    @(negedge clk);
    checkVal("peakLeft", prevTag, peakLeft, pkL);
    checkVal("peakRight", prevTag, peakRight, pkR);
    inValid = v; inLeft = l; inRight = r; volLeft = vl; volRight = vr;
    muteIn = m; rdPeakLeft = rl; rdPeakRight = rr;
    if (v) begin
      it.l = scaleOf(l, vl, m); it.r = scaleOf(r, vr, m); it.tag = tag;
      expQ.push_back(it);
    end
    if (rl) pkL = v ? magOf(l) : '0;
    else if (v && magOf(l) > pkL) pkL = magOf(l);
    if (rr) pkR = v ? magOf(r) : '0;
    else if (v && magOf(r) > pkR) pkR = magOf(r);
    prevTag = tag;
  endtask

  task automatic idle(string tag);
    step(1'b0, '0, '0, '0, '0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // monitor: compares produced pairs against the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2 unexpected outValid actual 1 expected 0");
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          checkVal("outLeft", e.tag, outLeft, e.l);
          checkVal("outRight", e.tag, outRight, e.r);
        end
      end else begin
        checkVal("outLeft hold", "R2", outLeft, lastL);
        checkVal("outRight hold", "R2", outRight, lastR);
      end
      lastL = outLeft;
      lastR = outRight;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("outValid", "R1", {23'b0, outValid}, 24'h0);
    checkVal("outLeft", "R1", outLeft, 24'h0);
    checkVal("peakLeft", "R1", peakLeft, 24'h0);
    checkVal("peakRight", "R1", peakRight, 24'h0);

    // R4 unity
    step(1'b1, 24'sh123456, -24'sd1000, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, "R4");
    idle("R2");
    // R3 general codes, independent channels, truncation toward zero
    step(1'b1, 24'sd1000, -24'sd1001, 8'd128, 8'd128, 1'b0, 1'b0, 1'b0, "R3");
    step(1'b1, 24'sd8388607, -24'sd3, 8'd1, 8'd200, 1'b0, 1'b0, 1'b0, "R3");
    step(1'b1, -24'sd777777, 24'sd4095, 8'd37, 8'd250, 1'b0, 1'b0, 1'b0, "R3");
    idle("R2");
    idle("R2");
    // R5 deepest attenuation
    step(1'b1, -24'sd8388608, 24'sd255, 8'd255, 8'd255, 1'b0, 1'b0, 1'b0, "R5");
    step(1'b1, 24'sd8388607, -24'sd300, 8'd255, 8'd255, 1'b0, 1'b0, 1'b0, "R5");
    // clear both peaks before the peak scenarios (R9)
    step(1'b0, '0, '0, '0, '0, 1'b0, 1'b1, 1'b1, "R9");
    idle("R9");
    // R6 mute, peak still taken
    step(1'b1, 24'sd5000, -24'sd7000, 8'd0, 8'd10, 1'b1, 1'b0, 1'b0, "R6");
    idle("R6");
    // R7 running maximum under deep volume and mute
    step(1'b1, 24'sd20000, 24'sd100, 8'd255, 8'd255, 1'b0, 1'b0, 1'b0, "R7");
    step(1'b1, -24'sd15000, -24'sd90000, 8'd255, 8'd0, 1'b1, 1'b0, 1'b0, "R7");
    step(1'b1, 24'sd3, -24'sd40000, 8'd4, 8'd4, 1'b0, 1'b0, 1'b0, "R7");
    idle("R7");
    // R9 read left only; right kept
    step(1'b0, '0, '0, '0, '0, 1'b0, 1'b1, 1'b0, "R9");
    idle("R9");
    idle("R9");
    // R10 read together with a sample on both channels
    step(1'b1, 24'sd12, -24'sd34, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, "R10");
    step(1'b1, 24'sd77, 24'sd5, 8'd0, 8'd0, 1'b0, 1'b1, 1'b1, "R10");
    idle("R10");
    // R8 most negative saturates
    step(1'b1, -24'sd8388608, -24'sd8388608, 8'd16, 8'd0, 1'b0, 1'b0, 1'b0, "R8");
    idle("R8");
    idle("R8");

    checkVal("queue empty", "R2", 24'(expQ.size()), 24'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule